// File: doc/BRIEF.md
# Masked Vector Execution Unit

This unit runs one element-wise integer operation over two source vectors per instruction. It holds a per-element mask and respects a requested vector length, so element positions past that length never take part. The two arithmetic operations (add and subtract) can handle the mask in one of two ways, selected per instruction:

- **Slot mode** steps through every in-range element position, one per cycle. It suppresses the write of any position whose mask bit is clear.
- **Packed mode** scans the mask and sends only the enabled positions down the pipeline, back to back.

A signed greater-than compare rewrites the mask from the sources. A separate mask-set command turns every element on again.

Elements of one instruction do not depend on each other. One element therefore enters the fixed-latency pipeline per cycle, with no hazard logic. After the final element of an instruction has entered, the unit stays closed for a programmable number of dead cycles before it accepts another instruction. A one-cycle completion pulse marks the last result of each instruction. The upstream sequencer watches `ready`, holds the operands on the source buses for the acceptance cycle, and collects results from the write port.

Top module: `mvx_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `ready` is 1, `wb_en` and `done` are 0, and `mask_out` is all ones.
- R2: Operation code 0 writes a[i]+b[i] and code 1 writes a[i]-b[i], both modulo 2^EW. The result appears on `wb_data` with `wb_idx` = i. Element i occupies bits [i*EW +: EW] of each source bus.
- R3: No element whose mask bit (as held when the instruction was accepted) is 0 ever raises `wb_en`, in either mode.
- R4: In slot mode (`dense` = 0) with an instruction accepted at clock edge S, element position i is at the write port just after edge S+LAT+i, for every i below the vector length.
- R5: In packed mode (`dense` = 1), the k-th enabled element (counting from 0) is written just after edge S+LAT+k.
- R6: Only positions below `vlen` are processed. Mask bits at or above `vlen` are ignored. A `vlen` above NELEM acts as NELEM.
- R7: Operation code 2 sets mask bit i to (signed a[i] > signed b[i]) for every i below `vlen`, whatever the current mask and mode. It keeps the bits at or above `vlen` and raises no `wb_en`.
- R8: Operation code 3 sets every mask bit to 1 and writes no element.
- R9: `done` pulses for exactly one cycle per instruction, in the cycle of its final slot. That slot is element `vlen`-1 in slot mode and the last enabled element in packed mode. When no slot holds an element (`vlen` 0, no enabled element in packed mode, or code 3), `done` pulses just after edge S+LAT with no write.
- R10: For an add or subtract instruction, `ready` is 0 from the cycle after acceptance. It becomes 1 again just after edge S+n+D, where D is `dead_cfg` and n is the number of slots issued, never fewer than 1.
- R11: A `start` pulse while `ready` is 0 is ignored: it produces no writes, no completion and no mask change.
- R12: Within one instruction, writes come out in strictly ascending element order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Instruction request, taken when `ready` is 1 |
| op | input | 2 | 0 add, 1 subtract, 2 compare-greater into mask, 3 set all mask bits |
| dense | input | 1 | 1 selects packed mode, 0 selects slot mode |
| vlen | input | LW | Vector length for this instruction |
| dead_cfg | input | DW | Dead cycles after the last slot |
| src_a | input | NELEM*EW | First source vector |
| src_b | input | NELEM*EW | Second source vector |
| ready | output | 1 | Unit can accept an instruction this cycle |
| wb_en | output | 1 | Element result write strobe |
| wb_idx | output | IW | Element index of the write |
| wb_data | output | EW | Element result |
| done | output | 1 | Final slot of an instruction leaves the pipeline |
| mask_out | output | NELEM | Current mask register |

## Verification
The hardest situation to reach is a start request that arrives while the unit is still busy, at a moment when the ignored command would visibly change the state. The bench first clears the mask with a compare. It then starts a slot-mode add with a long dead time, and in the very next cycle raises `start` with the mask-set code. If that command were wrongly taken, every mask bit would turn on and the masked add would produce writes. The scoreboard would flag those writes as unexpected, and the final mask readback would show the change.

A second hard case is a packed-mode instruction whose mask is entirely clear. There the only evidence of execution is the completion pulse arriving exactly LAT cycles after acceptance.

// File: rtl/mvx_pkg.sv
package mvx_pkg;

    // Operation codes of the vector unit
    typedef enum logic [1:0] {
        VOP_ADD   = 2'd0,
        VOP_SUB   = 2'd1,
        VOP_CMPGT = 2'd2,
        VOP_MSET  = 2'd3
    } vop_e;

endpackage

// File: rtl/mvx_issue.sv
// Instruction latch, element sequencer and dead-time counter.
module mvx_issue
    import mvx_pkg::*;
#(
    parameter int NELEM = 8,
    parameter int EW    = 16,
    parameter int DW    = 4,
    localparam int IW   = (NELEM > 1) ? $clog2(NELEM) : 1,
    localparam int LW   = $clog2(NELEM + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  accept,
    input  vop_e                  op,
    input  logic                  dense,
    input  logic [LW-1:0]         vlen,
    input  logic [DW-1:0]         dead_cfg,
    input  logic [NELEM*EW-1:0]   src_a,
    input  logic [NELEM*EW-1:0]   src_b,
    input  logic [NELEM-1:0]      mask_in,
    output logic                  idle,
    output logic                  tk_v,
    output logic                  tk_elem,
    output logic                  tk_wen,
    output logic                  tk_last,
    output logic [IW-1:0]         tk_idx,
    output vop_e                  tk_op,
    output logic [EW-1:0]         tk_a,
    output logic [EW-1:0]         tk_b
);

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DEAD} st_e;

    typedef struct packed {
        st_e                  st;
        vop_e                 op;
        logic                 dense;
        logic [LW-1:0]        vlen;
        logic [DW-1:0]        dead;
        logic [DW-1:0]        cnt;
        logic [NELEM-1:0]     msk;
        logic [LW-1:0]        cur;
        logic [NELEM*EW-1:0]  a;
        logic [NELEM*EW-1:0]  b;
    } iss_t;

    iss_t q, d;

    // Index of the lowest set bit
    function automatic logic [IW-1:0] low_idx(input logic [NELEM-1:0] v);
        logic [IW-1:0] r;
        r = '0;
        for (int i = NELEM - 1; i >= 0; i--) begin
            if (v[i]) r = IW'(i);
        end
        return r;
    endfunction

    logic [NELEM-1:0] in_rng;
    logic [NELEM-1:0] at_or_above;
    logic [NELEM-1:0] remain;
    logic [NELEM-1:0] low_hot;
    logic             arith;
    logic [LW-1:0]    cur_nx;

    always_comb begin
        d       = q;
        tk_v    = 1'b0;
        tk_elem = 1'b0;
        tk_wen  = 1'b0;
        tk_last = 1'b0;
        tk_idx  = '0;
        tk_op   = q.op;

        for (int i = 0; i < NELEM; i++) begin
            in_rng[i]      = (LW'(i) < q.vlen);
            at_or_above[i] = (LW'(i) >= q.cur);
        end
        remain  = q.msk & in_rng & at_or_above;
        low_hot = remain & (~remain + NELEM'(1));
        arith   = (q.op == VOP_ADD) || (q.op == VOP_SUB);
        cur_nx  = q.cur + LW'(1);

        unique case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    d.st    = ST_RUN;
                    d.op    = op;
                    d.dense = dense;
                    d.vlen  = (vlen > LW'(NELEM)) ? LW'(NELEM) : vlen;
                    d.dead  = dead_cfg;
                    d.msk   = mask_in;
                    d.cur   = '0;
                    d.a     = src_a;
                    d.b     = src_b;
                end
            end
            ST_RUN: begin
                tk_v = 1'b1;
                if (q.op == VOP_MSET || q.vlen == '0) begin
                    tk_last = 1'b1;
                end else if (q.dense && arith) begin
                    if (remain == '0) begin
                        tk_last = 1'b1;
                    end else begin
                        tk_idx  = low_idx(remain);
                        tk_elem = 1'b1;
                        tk_wen  = 1'b1;
                        tk_last = ((remain & ~low_hot) == '0);
                        d.cur   = LW'(tk_idx) + LW'(1);
                    end
                end else begin
                    tk_idx  = q.cur[IW-1:0];
                    tk_elem = 1'b1;
                    tk_wen  = arith && q.msk[tk_idx];
                    tk_last = (cur_nx == q.vlen);
                    d.cur   = cur_nx;
                end
                if (tk_last) begin
                    d.cnt = q.dead;
                    d.st  = (q.dead == '0) ? ST_IDLE : ST_DEAD;
                end
            end
            ST_DEAD: begin
                d.cnt = q.cnt - DW'(1);
                if (q.cnt == DW'(1)) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase

        tk_a = q.a[int'(tk_idx) * EW +: EW];
        tk_b = q.b[int'(tk_idx) * EW +: EW];
        idle = (q.st == ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/mvx_pipe.sv
// Fixed-latency element pipeline: operand stage, then result stages.
module mvx_pipe
    import mvx_pkg::*;
#(
    parameter int EW  = 16,
    parameter int IW  = 3,
    parameter int LAT = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tk_v,
    input  logic           tk_elem,
    input  logic           tk_wen,
    input  logic           tk_last,
    input  logic [IW-1:0]  tk_idx,
    input  vop_e           tk_op,
    input  logic [EW-1:0]  tk_a,
    input  logic [EW-1:0]  tk_b,
    output logic           o_v,
    output logic           o_elem,
    output logic           o_wen,
    output logic           o_last,
    output logic [IW-1:0]  o_idx,
    output vop_e           o_op,
    output logic [EW-1:0]  o_res,
    output logic           o_gt,
    output logic           mask_busy
);

    localparam int NRES = LAT - 1;

    typedef struct packed {
        logic           v;
        logic           elem;
        logic           wen;
        logic           last;
        logic [IW-1:0]  idx;
        vop_e           op;
        logic [EW-1:0]  a;
        logic [EW-1:0]  b;
    } opnd_t;

    typedef struct packed {
        logic           v;
        logic           elem;
        logic           wen;
        logic           last;
        logic [IW-1:0]  idx;
        vop_e           op;
        logic [EW-1:0]  res;
        logic           gt;
    } rslt_t;

    opnd_t s1_q, s1_d;
    rslt_t sr_q [NRES];
    rslt_t sr_d [NRES];

    function automatic logic is_mask_op(input vop_e o);
        return (o == VOP_CMPGT) || (o == VOP_MSET);
    endfunction

    always_comb begin
        s1_d.v    = tk_v;
        s1_d.elem = tk_elem;
        s1_d.wen  = tk_wen;
        s1_d.last = tk_last;
        s1_d.idx  = tk_idx;
        s1_d.op   = tk_op;
        s1_d.a    = tk_a;
        s1_d.b    = tk_b;

        sr_d[0].v    = s1_q.v;
        sr_d[0].elem = s1_q.elem;
        sr_d[0].wen  = s1_q.wen;
        sr_d[0].last = s1_q.last;
        sr_d[0].idx  = s1_q.idx;
        sr_d[0].op   = s1_q.op;
        sr_d[0].res  = (s1_q.op == VOP_SUB) ? (s1_q.a - s1_q.b) : (s1_q.a + s1_q.b);
        sr_d[0].gt   = ($signed(s1_q.a) > $signed(s1_q.b));
        for (int k = 1; k < NRES; k++) begin
            sr_d[k] = sr_q[k-1];
        end

        mask_busy = s1_q.v && is_mask_op(s1_q.op);
        for (int k = 0; k < NRES; k++) begin
            mask_busy = mask_busy || (sr_q[k].v && is_mask_op(sr_q[k].op));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            for (int k = 0; k < NRES; k++) sr_q[k] <= '0;
        end else begin
            s1_q <= s1_d;
            sr_q <= sr_d;
        end
    end

    assign o_v    = sr_q[NRES-1].v;
    assign o_elem = sr_q[NRES-1].elem;
    assign o_wen  = sr_q[NRES-1].wen;
    assign o_last = sr_q[NRES-1].last;
    assign o_idx  = sr_q[NRES-1].idx;
    assign o_op   = sr_q[NRES-1].op;
    assign o_res  = sr_q[NRES-1].res;
    assign o_gt   = sr_q[NRES-1].gt;

endmodule

// File: rtl/mvx_mask.sv
// Per-element mask register, updated from the pipeline output.
module mvx_mask
    import mvx_pkg::*;
#(
    parameter int NELEM = 8,
    parameter int IW    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_v,
    input  vop_e              upd_op,
    input  logic              upd_elem,
    input  logic [IW-1:0]     upd_idx,
    input  logic              upd_gt,
    output logic [NELEM-1:0]  mask
);

    logic [NELEM-1:0] mask_q, mask_d;

    always_comb begin
        mask_d = mask_q;
        if (upd_v && upd_op == VOP_MSET) begin
            mask_d = '1;
        end else if (upd_v && upd_elem && upd_op == VOP_CMPGT) begin
            mask_d[upd_idx] = upd_gt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '1;
        else        mask_q <= mask_d;
    end

    assign mask = mask_q;

endmodule

// File: rtl/mvx_unit.sv
// Top level of the masked vector execution unit.
module mvx_unit
    import mvx_pkg::*;
#(
    parameter int NELEM = 8,
    parameter int EW    = 16,
    parameter int LAT   = 3,
    parameter int DW    = 4,
    localparam int IW   = (NELEM > 1) ? $clog2(NELEM) : 1,
    localparam int LW   = $clog2(NELEM + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [1:0]           op,
    input  logic                 dense,
    input  logic [LW-1:0]        vlen,
    input  logic [DW-1:0]        dead_cfg,
    input  logic [NELEM*EW-1:0]  src_a,
    input  logic [NELEM*EW-1:0]  src_b,
    output logic                 ready,
    output logic                 wb_en,
    output logic [IW-1:0]        wb_idx,
    output logic [EW-1:0]        wb_data,
    output logic                 done,
    output logic [NELEM-1:0]     mask_out
);

    logic           idle, accept, mask_busy;
    logic           tk_v, tk_elem, tk_wen, tk_last;
    logic [IW-1:0]  tk_idx;
    vop_e           tk_op;
    logic [EW-1:0]  tk_a, tk_b;
    logic           o_v, o_elem, o_wen, o_last, o_gt;
    logic [IW-1:0]  o_idx;
    vop_e           o_op;
    logic [EW-1:0]  o_res;

    assign ready  = idle && !mask_busy;
    assign accept = start && ready;

    mvx_issue #(.NELEM(NELEM), .EW(EW), .DW(DW)) u_issue (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .op       (vop_e'(op)),
        .dense    (dense),
        .vlen     (vlen),
        .dead_cfg (dead_cfg),
        .src_a    (src_a),
        .src_b    (src_b),
        .mask_in  (mask_out),
        .idle     (idle),
        .tk_v     (tk_v),
        .tk_elem  (tk_elem),
        .tk_wen   (tk_wen),
        .tk_last  (tk_last),
        .tk_idx   (tk_idx),
        .tk_op    (tk_op),
        .tk_a     (tk_a),
        .tk_b     (tk_b)
    );

    mvx_pipe #(.EW(EW), .IW(IW), .LAT(LAT)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .tk_v      (tk_v),
        .tk_elem   (tk_elem),
        .tk_wen    (tk_wen),
        .tk_last   (tk_last),
        .tk_idx    (tk_idx),
        .tk_op     (tk_op),
        .tk_a      (tk_a),
        .tk_b      (tk_b),
        .o_v       (o_v),
        .o_elem    (o_elem),
        .o_wen     (o_wen),
        .o_last    (o_last),
        .o_idx     (o_idx),
        .o_op      (o_op),
        .o_res     (o_res),
        .o_gt      (o_gt),
        .mask_busy (mask_busy)
    );

    mvx_mask #(.NELEM(NELEM), .IW(IW)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_v    (o_v),
        .upd_op   (o_op),
        .upd_elem (o_elem),
        .upd_idx  (o_idx),
        .upd_gt   (o_gt),
        .mask     (mask_out)
    );

    assign wb_en   = o_v && o_wen;
    assign wb_idx  = o_idx;
    assign wb_data = o_res;
    assign done    = o_v && o_last;

endmodule

// File: rtl/mvx_unit_sva.sv
// Property checker for mvx_unit, attached with bind.
module mvx_unit_sva #(
    parameter int NELEM = 8,
    parameter int IW    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              ready,
    input logic              wb_en,
    input logic [IW-1:0]     wb_idx,
    input logic              done,
    input logic [NELEM-1:0]  mask_out
);

    logic          have_prev;
    logic [IW-1:0] prev_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_prev <= 1'b0;
            prev_idx  <= '0;
        end else if (done) begin
            have_prev <= 1'b0;
        end else if (wb_en) begin
            have_prev <= 1'b1;
            prev_idx  <= wb_idx;
        end
    end

    // R3: a write only ever comes from an enabled element
    a_r3_write_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> mask_out[wb_idx]);

    // R12: ascending write order inside one instruction
    a_r12_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && have_prev) |-> (wb_idx > prev_idx));

    // R10: acceptance closes the unit in the following cycle
    a_r10_accept_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready) |=> !ready);

    // R11: the mask only moves while the unit is closed
    a_r11_mask_moves_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mask_out) |-> !$past(ready));

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind mvx_unit mvx_unit_sva #(.NELEM(NELEM), .IW(IW)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .ready    (ready),
    .wb_en    (wb_en),
    .wb_idx   (wb_idx),
    .done     (done),
    .mask_out (mask_out)
);

// File: tb/mvx_unit_tb.sv
module mvx_unit_tb;

    localparam int NELEM = 8;
    localparam int EW    = 16;
    localparam int LAT   = 3;
    localparam int DW    = 4;
    localparam int IW    = $clog2(NELEM);
    localparam int LW    = $clog2(NELEM + 1);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [1:0]           op = 2'd0;
    logic                 dense = 1'b0;
    logic [LW-1:0]        vlen = '0;
    logic [DW-1:0]        dead_cfg = '0;
    logic [NELEM*EW-1:0]  src_a, src_b;
    logic                 ready, wb_en, done;
    logic [IW-1:0]        wb_idx;
    logic [EW-1:0]        wb_data;
    logic [NELEM-1:0]     mask_out;

    logic [EW-1:0]        av [NELEM];
    logic [EW-1:0]        bv [NELEM];
    logic [NELEM-1:0]     exp_mask = '1;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int            q_idx [$];
    int            q_cyc [$];
    logic [EW-1:0] q_dat [$];
    int            q_done [$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always_comb begin
        for (int i = 0; i < NELEM; i++) begin
            src_a[i*EW +: EW] = av[i];
            src_b[i*EW +: EW] = bv[i];
        end
    end

    mvx_unit #(.NELEM(NELEM), .EW(EW), .LAT(LAT), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .dense(dense),
        .vlen(vlen), .dead_cfg(dead_cfg), .src_a(src_a), .src_b(src_b),
        .ready(ready), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
        .done(done), .mask_out(mask_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, expv, cyc);
        end
    endtask

    // Monitor: pop expected writes and completions as they appear
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (wb_en) begin
                if (q_idx.size() == 0) begin
                    chk(1'b0, "R3 R11", "unexpected write index", wb_idx, -1);
                end else begin
                    int ei, ec;
                    logic [EW-1:0] ed;
                    ei = q_idx.pop_front();
                    ec = q_cyc.pop_front();
                    ed = q_dat.pop_front();
                    chk(int'(wb_idx) == ei, "R12 R6", "write index", wb_idx, ei);
                    chk(wb_data == ed, "R2", "write data", wb_data, ed);
                    chk(cyc == ec, "R4 R5", "write cycle", cyc, ec);
                end
            end
            if (done) begin
                if (q_done.size() == 0) begin
                    chk(1'b0, "R9 R11", "unexpected done", cyc, -1);
                end else begin
                    int dc;
                    dc = q_done.pop_front();
                    chk(cyc == dc, "R9", "done cycle", cyc, dc);
                end
            end
        end
    end

    task automatic set_ab(input int seed);
        for (int i = 0; i < NELEM; i++) begin
            av[i] = EW'(seed * 4099 + i * 9173 - 20000);
            bv[i] = EW'(seed * 1531 - i * 6007 + 3000);
        end
    endtask

    // Driver: issue one instruction and push the expected results
    task automatic launch(input logic [1:0] opc, input bit dns, input int vl,
                          input int dd, input bit poke);
        int s, vle, n, k;
        @(negedge clk);
        while (!ready) @(negedge clk);
        s   = cyc + 1;
        vle = (vl > NELEM) ? NELEM : vl;
        n   = 0;
        if (opc == 2'd0 || opc == 2'd1) begin
            k = 0;
            for (int i = 0; i < vle; i++) begin
                if (exp_mask[i]) begin
                    q_idx.push_back(i);
                    q_dat.push_back(opc == 2'd0 ? EW'(av[i] + bv[i]) : EW'(av[i] - bv[i]));
                    q_cyc.push_back(s + LAT + (dns ? k : i));
                    k++;
                end
            end
            n = dns ? k : vle;
        end else if (opc == 2'd2) begin
            n = vle;
        end
        if (n < 1) n = 1;
        q_done.push_back(s + LAT + n - 1);

        start = 1'b1; op = opc; dense = dns; vlen = LW'(vl); dead_cfg = DW'(dd);
        @(negedge clk);
        start = 1'b0;
        chk(ready == 1'b0, "R10", "ready after accept", ready, 0);
        if (poke) begin
            start = 1'b1; op = 2'd3;
            @(negedge clk);
            start = 1'b0;
        end
        if (opc == 2'd2) begin
            for (int i = 0; i < vle; i++)
                exp_mask[i] = ($signed(av[i]) > $signed(bv[i]));
        end else if (opc == 2'd3) begin
            exp_mask = '1;
        end
        if (opc == 2'd0 || opc == 2'd1) begin
            while (cyc < s + n + dd - 1) @(negedge clk);
            chk(ready == 1'b0, "R10", "ready in last closed cycle", ready, 0);
            @(negedge clk);
            chk(ready == 1'b1, "R10", "ready reopens", ready, 1);
        end else begin
            while (!ready) @(negedge clk);
            chk(mask_out == exp_mask, opc == 2'd2 ? "R7" : "R8", "mask after op",
                mask_out, exp_mask);
        end
    endtask

    task automatic drain;
        int guard;
        guard = 0;
        while ((q_idx.size() != 0 || q_done.size() != 0) && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R9 watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        set_ab(1);
        repeat (3) @(negedge clk);
        // R1: reset values, during reset and just after
        chk(ready == 1'b1, "R1", "ready in reset", ready, 1);
        chk(wb_en == 1'b0 && done == 1'b0, "R1", "no output in reset", {wb_en, done}, 0);
        chk(mask_out == '1, "R1", "mask in reset", mask_out, 8'hFF);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready == 1'b1 && mask_out == '1, "R1", "state after reset", {ready, mask_out}, 9'h1FF);

        // R7: compare builds a mixed mask over the full length
        set_ab(3);
        launch(2'd2, 1'b0, 8, 0, 1'b0);
        // R2 R3 R4 R10: slot-mode add
        set_ab(5);
        launch(2'd0, 1'b0, 8, 2, 1'b0);
        // R5: packed-mode subtract
        launch(2'd1, 1'b1, 8, 4, 1'b0);
        // R6: enabled bits above the length are ignored
        launch(2'd0, 1'b1, 5, 1, 1'b0);
        // R7: partial-length compare keeps high bits, signed data
        set_ab(-7);
        launch(2'd2, 1'b1, 5, 0, 1'b0);
        launch(2'd1, 1'b0, 7, 0, 1'b0);
        // R9: zero length, done without any write
        launch(2'd0, 1'b0, 0, 1, 1'b0);
        // R8: set all mask bits
        launch(2'd3, 1'b0, 4, 0, 1'b0);
        // R6: length beyond NELEM acts as NELEM
        launch(2'd0, 1'b0, 12, 0, 1'b0);
        // R9: all-clear mask in packed mode
        for (int i = 0; i < NELEM; i++) begin av[i] = '0; bv[i] = EW'(1); end
        launch(2'd2, 1'b0, 8, 0, 1'b0);
        chk(mask_out == '0, "R7", "all-clear mask", mask_out, 0);
        launch(2'd0, 1'b1, 8, 0, 1'b0);
        // R11: a mask-set request while busy is ignored
        launch(2'd0, 1'b0, 4, 3, 1'b1);
        drain();
        chk(mask_out == '0, "R11", "mask after ignored start", mask_out, 0);
        // R12 R5: back-to-back packed instructions with no dead time
        launch(2'd3, 1'b0, 1, 0, 1'b0);
        set_ab(9);
        launch(2'd2, 1'b0, 8, 0, 1'b0);
        launch(2'd0, 1'b1, 8, 0, 1'b0);
        launch(2'd1, 1'b1, 6, 0, 1'b0);
        drain();
        chk(q_idx.size() == 0, "R3", "writes outstanding", q_idx.size(), 0);
        chk(q_done.size() == 0, "R9", "completions outstanding", q_done.size(), 0);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule